// File: doc/BRIEF.md
# Host Messaging and Doorbell Unit

This block is the mailbox between a local CPU and a remote agent on the PCI side. Each side has its own simple register port: address, write strobe, read strobe, write data and registered read data. The CPU posts two 32-bit outbound messages and rings an outbound doorbell. The PCI agent posts two 32-bit inbound messages and rings an inbound doorbell. Every event is recorded in a cause register for its direction. A mask register gates each cause onto one level interrupt per direction: `irq_cpu` for inbound events and `irq_pci` for outbound events.

Only the receiving side can clear a cause. The CPU clears inbound causes by writing ones. The PCI agent clears an outbound message cause by reading that message and clears outbound doorbell bits by writing ones. An external circular-queue engine sends a one-cycle pulse when an inbound post arrives. The block keeps that pulse as a sticky cause bit. Each interrupt stays high while any unmasked cause remains set.

Both ports decode byte addresses with the same word layout. The message registers of the local side are at 0x00/0x04, and the messages that the peer sends are at 0x08/0x0C. The other registers are: outbound doorbell 0x10, inbound doorbell 0x14, inbound cause 0x18, inbound mask 0x1C, outbound cause 0x20 and outbound mask 0x24. Cause and mask bits are: 0 for message 0, 1 for message 1, 2 for doorbell (any bit set), 4 for queue post. Bit 3 always reads 0.

Top module: `msg_doorbell_unit`

## Requirements
- R1: After reset, all message and doorbell registers and both cause registers read 0, both mask registers read 0x1F, and `irq_cpu` and `irq_pci` are low.
- R2: A CPU write to 0x00 or 0x04 stores outbound message 0 or 1. The PCI side reads that message at 0x08 or 0x0C, and outbound cause bit 0 or 1 is set.
- R3: Outbound message cause bit k clears only when the PCI side reads outbound message k. A CPU write of ones to the outbound cause register (0x20) has no effect.
- R4: A PCI write to 0x00 or 0x04 stores inbound message 0 or 1, which the CPU reads at 0x08 or 0x0C, and sets inbound cause bit 0 or 1. The CPU clears these bits by writing ones to 0x18. PCI writes to 0x18 have no effect.
- R5: In the outbound doorbell (0x10), CPU writes set the bits written as 1 and PCI writes clear the bits written as 1. Zero bits have no effect. Outbound cause bit 2 is 1 while any doorbell bit is set.
- R6: In the inbound doorbell (0x14), PCI writes set the bits written as 1 and CPU writes clear the bits written as 1. Zero bits have no effect. Inbound cause bit 2 is 1 while any doorbell bit is set.
- R7: A one-cycle pulse on `queue_post_evt` sets inbound cause bit 4, which holds until the CPU writes 1 to bit 4 of 0x18. Cause bit 3 always reads 0.
- R8: The CPU writes the masks at 0x1C (inbound) and 0x24 (outbound). A mask bit of 1 keeps its cause off the interrupt, but the cause bit is still recorded and readable.
- R9: Each interrupt is the registered OR of cause AND NOT mask over bits 0, 1, 2 and 4. It changes exactly one cycle after the cause or mask register changes, and stays high until every unmasked cause is clear.
- R10: When a set and a clear of the same cause or doorbell bit come in the same cycle, the set wins.
- R11: Read data appears on the cycle after the read strobe and holds until the next read. Unmapped addresses and addresses with nonzero low two bits read 0, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_addr | input | ADDR_W | CPU byte address |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_wdata | input | DATA_W | CPU write data |
| cpu_rdata | output | DATA_W | CPU read data, registered |
| pci_addr | input | ADDR_W | PCI-side byte address |
| pci_wr | input | 1 | PCI-side write strobe |
| pci_rd | input | 1 | PCI-side read strobe |
| pci_wdata | input | DATA_W | PCI-side write data |
| pci_rdata | output | DATA_W | PCI-side read data, registered |
| queue_post_evt | input | 1 | Inbound post queue event pulse |
| irq_cpu | output | 1 | Level interrupt to the CPU (inbound causes) |
| irq_pci | output | 1 | Level interrupt to the PCI agent (outbound causes) |

## Verification
A write or a read-clear at one rising edge changes the cause and data registers at that same edge. The result is visible through a read issued on the following cycle. `irq_cpu` and `irq_pci` follow one edge later. Read data is ready one edge after the strobe. The bench drives every strobe on the falling edge and checks read data at the next falling edge. For interrupts, it first checks at the falling edge right after the stimulus, where the old level must still be present. It checks again one cycle later for the new level. In this way the extra register stage is tested, not just the final state. Set-wins collisions are driven with both ports active at the same falling edge.

// File: rtl/mdu_pkg.sv
`timescale 1ns/1ps
package mdu_pkg;
  localparam int unsigned CAUSE_W   = 5;
  localparam int unsigned CB_MSG0   = 0;
  localparam int unsigned CB_MSG1   = 1;
  localparam int unsigned CB_DB     = 2;
  localparam int unsigned CB_QPOST  = 4;
  localparam logic [CAUSE_W-1:0] IRQ_SRC = 5'b10111;
  localparam logic [CAUSE_W-1:0] MASK_RST = '1;

  // word indices (byte address / 4)
  localparam int unsigned RA_OWN_MSG0  = 0;
  localparam int unsigned RA_PEER_MSG0 = 2;
  localparam int unsigned RA_DB_OUT    = 4;
  localparam int unsigned RA_DB_IN     = 5;
  localparam int unsigned RA_IN_CAUSE  = 6;
  localparam int unsigned RA_IN_MASK   = 7;
  localparam int unsigned RA_OB_CAUSE  = 8;
  localparam int unsigned RA_OB_MASK   = 9;
endpackage

// File: rtl/mdu_rst_sync.sv
`timescale 1ns/1ps
module mdu_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] stg_q;
  logic [STAGES-1:0] stg_d;

  always_comb stg_d = {stg_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= '0;
    else        stg_q <= stg_d;
  end

  assign rst_sync_n = stg_q[STAGES-1];
endmodule

// File: rtl/mdu_msg_bank.sv
`timescale 1ns/1ps
module mdu_msg_bank #(
  parameter int DATA_W = 32,
  parameter int NUM    = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM-1:0]               wr_en,
  input  logic [DATA_W-1:0]            wdata,
  input  logic [NUM-1:0]               clr,
  output logic [NUM-1:0][DATA_W-1:0]   msg_q,
  output logic [NUM-1:0]               flag_q
);
  logic [NUM-1:0] flag_d;

  // a fresh write wins over a same-cycle clear
  always_comb flag_d = wr_en | (flag_q & ~clr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= flag_d;
  end

  for (genvar g = 0; g < NUM; g++) begin : g_slot
    logic [DATA_W-1:0] data_r;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        data_r <= '0;
      else if (wr_en[g]) data_r <= wdata;
    end
    assign msg_q[g] = data_r;
  end
endmodule

// File: rtl/mdu_doorbell.sv
`timescale 1ns/1ps
module mdu_doorbell #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_en,
  input  logic [W-1:0] set_bits,
  input  logic         clr_en,
  input  logic [W-1:0] clr_bits,
  output logic [W-1:0] bell_q,
  output logic         any_set
);
  logic [W-1:0] bell_d;
  logic [W-1:0] set_m;
  logic [W-1:0] clr_m;

  always_comb begin
    set_m  = set_en ? set_bits : '0;
    clr_m  = clr_en ? clr_bits : '0;
    bell_d = (bell_q & ~clr_m) | set_m;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bell_q <= '0;
    else        bell_q <= bell_d;
  end

  assign any_set = |bell_q;
endmodule

// File: rtl/mdu_irq_ctrl.sv
`timescale 1ns/1ps
module mdu_irq_ctrl #(
  parameter int             CW  = 5,
  parameter logic [CW-1:0]  SRC = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cause,
  input  logic [CW-1:0] mask,
  output logic          irq_q
);
  logic irq_d;

  always_comb irq_d = |(cause & ~mask & SRC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end
endmodule

// File: rtl/msg_doorbell_unit.sv
`timescale 1ns/1ps
module msg_doorbell_unit
  import mdu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 6,
  parameter int N_MSG  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_wr,
  input  logic              cpu_rd,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  input  logic [ADDR_W-1:0] pci_addr,
  input  logic              pci_wr,
  input  logic              pci_rd,
  input  logic [DATA_W-1:0] pci_wdata,
  output logic [DATA_W-1:0] pci_rdata,
  input  logic              queue_post_evt,
  output logic              irq_cpu,
  output logic              irq_pci
);
  localparam int WORD_W = ADDR_W - 2;

  logic rst_int_n;
  logic [WORD_W-1:0] cpu_word, pci_word;
  logic cpu_ok, pci_ok;

  logic [N_MSG-1:0] cpu_we_own, pci_we_own, pci_rd_peer, cpu_clr_in;
  logic [N_MSG-1:0][DATA_W-1:0] ob_msg, ib_msg;
  logic [N_MSG-1:0] ob_flag, ib_flag;

  logic cpu_we_dbo, pci_we_dbo, cpu_we_dbi, pci_we_dbi;
  logic [DATA_W-1:0] ob_db, ib_db;
  logic ob_db_any, ib_db_any;

  logic cpu_we_icause, cpu_we_imask, cpu_we_omask;
  logic qpost_q, qpost_d;
  logic [CAUSE_W-1:0] in_mask, in_mask_d, ob_mask, ob_mask_d;
  logic [CAUSE_W-1:0] in_cause, ob_cause;
  logic [DATA_W-1:0] cpu_rdata_d, pci_rdata_d;

  mdu_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_int_n)
  );

  // ---------------- address decode ----------------
  always_comb begin
    cpu_word = cpu_addr[ADDR_W-1:2];
    pci_word = pci_addr[ADDR_W-1:2];
    cpu_ok   = (cpu_addr[1:0] == 2'b00);
    pci_ok   = (pci_addr[1:0] == 2'b00);
    for (int k = 0; k < N_MSG; k++) begin
      cpu_we_own[k]  = cpu_wr && cpu_ok && (cpu_word == WORD_W'(RA_OWN_MSG0 + k));
      pci_we_own[k]  = pci_wr && pci_ok && (pci_word == WORD_W'(RA_OWN_MSG0 + k));
      pci_rd_peer[k] = pci_rd && pci_ok && (pci_word == WORD_W'(RA_PEER_MSG0 + k));
    end
    cpu_we_dbo    = cpu_wr && cpu_ok && (cpu_word == WORD_W'(RA_DB_OUT));
    pci_we_dbo    = pci_wr && pci_ok && (pci_word == WORD_W'(RA_DB_OUT));
    cpu_we_dbi    = cpu_wr && cpu_ok && (cpu_word == WORD_W'(RA_DB_IN));
    pci_we_dbi    = pci_wr && pci_ok && (pci_word == WORD_W'(RA_DB_IN));
    cpu_we_icause = cpu_wr && cpu_ok && (cpu_word == WORD_W'(RA_IN_CAUSE));
    cpu_we_imask  = cpu_wr && cpu_ok && (cpu_word == WORD_W'(RA_IN_MASK));
    cpu_we_omask  = cpu_wr && cpu_ok && (cpu_word == WORD_W'(RA_OB_MASK));
    for (int k = 0; k < N_MSG; k++)
      cpu_clr_in[k] = cpu_we_icause && cpu_wdata[k];
  end

  // ---------------- messages ----------------
  mdu_msg_bank #(.DATA_W(DATA_W), .NUM(N_MSG)) u_ob_msg (
    .clk(clk), .rst_n(rst_int_n), .wr_en(cpu_we_own), .wdata(cpu_wdata),
    .clr(pci_rd_peer), .msg_q(ob_msg), .flag_q(ob_flag)
  );

  mdu_msg_bank #(.DATA_W(DATA_W), .NUM(N_MSG)) u_ib_msg (
    .clk(clk), .rst_n(rst_int_n), .wr_en(pci_we_own), .wdata(pci_wdata),
    .clr(cpu_clr_in), .msg_q(ib_msg), .flag_q(ib_flag)
  );

  // ---------------- doorbells ----------------
  mdu_doorbell #(.W(DATA_W)) u_ob_db (
    .clk(clk), .rst_n(rst_int_n),
    .set_en(cpu_we_dbo), .set_bits(cpu_wdata),
    .clr_en(pci_we_dbo), .clr_bits(pci_wdata),
    .bell_q(ob_db), .any_set(ob_db_any)
  );

  mdu_doorbell #(.W(DATA_W)) u_ib_db (
    .clk(clk), .rst_n(rst_int_n),
    .set_en(pci_we_dbi), .set_bits(pci_wdata),
    .clr_en(cpu_we_dbi), .clr_bits(cpu_wdata),
    .bell_q(ib_db), .any_set(ib_db_any)
  );

  // ---------------- queue cause, masks ----------------
  always_comb begin
    qpost_d   = queue_post_evt | (qpost_q & ~(cpu_we_icause & cpu_wdata[CB_QPOST]));
    in_mask_d = cpu_we_imask ? cpu_wdata[CAUSE_W-1:0] : in_mask;
    ob_mask_d = cpu_we_omask ? cpu_wdata[CAUSE_W-1:0] : ob_mask;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      qpost_q <= 1'b0;
      in_mask <= MASK_RST;
      ob_mask <= MASK_RST;
    end else begin
      qpost_q <= qpost_d;
      in_mask <= in_mask_d;
      ob_mask <= ob_mask_d;
    end
  end

  always_comb begin
    in_cause           = '0;
    in_cause[CB_MSG0]  = ib_flag[0];
    in_cause[CB_MSG1]  = ib_flag[1];
    in_cause[CB_DB]    = ib_db_any;
    in_cause[CB_QPOST] = qpost_q;
    ob_cause           = '0;
    ob_cause[CB_MSG0]  = ob_flag[0];
    ob_cause[CB_MSG1]  = ob_flag[1];
    ob_cause[CB_DB]    = ob_db_any;
  end

  // ---------------- interrupts ----------------
  mdu_irq_ctrl #(.CW(CAUSE_W), .SRC(IRQ_SRC)) u_irq_cpu (
    .clk(clk), .rst_n(rst_int_n), .cause(in_cause), .mask(in_mask), .irq_q(irq_cpu)
  );

  mdu_irq_ctrl #(.CW(CAUSE_W), .SRC(IRQ_SRC)) u_irq_pci (
    .clk(clk), .rst_n(rst_int_n), .cause(ob_cause), .mask(ob_mask), .irq_q(irq_pci)
  );

  // ---------------- read paths ----------------
  always_comb begin
    cpu_rdata_d = '0;
    if (cpu_ok) begin
      for (int k = 0; k < N_MSG; k++) begin
        if (cpu_word == WORD_W'(RA_OWN_MSG0 + k))  cpu_rdata_d = ob_msg[k];
        if (cpu_word == WORD_W'(RA_PEER_MSG0 + k)) cpu_rdata_d = ib_msg[k];
      end
      if (cpu_word == WORD_W'(RA_DB_OUT))   cpu_rdata_d = ob_db;
      if (cpu_word == WORD_W'(RA_DB_IN))    cpu_rdata_d = ib_db;
      if (cpu_word == WORD_W'(RA_IN_CAUSE)) cpu_rdata_d = DATA_W'(in_cause);
      if (cpu_word == WORD_W'(RA_IN_MASK))  cpu_rdata_d = DATA_W'(in_mask);
      if (cpu_word == WORD_W'(RA_OB_CAUSE)) cpu_rdata_d = DATA_W'(ob_cause);
      if (cpu_word == WORD_W'(RA_OB_MASK))  cpu_rdata_d = DATA_W'(ob_mask);
    end
  end

  always_comb begin
    pci_rdata_d = '0;
    if (pci_ok) begin
      for (int k = 0; k < N_MSG; k++) begin
        if (pci_word == WORD_W'(RA_OWN_MSG0 + k))  pci_rdata_d = ib_msg[k];
        if (pci_word == WORD_W'(RA_PEER_MSG0 + k)) pci_rdata_d = ob_msg[k];
      end
      if (pci_word == WORD_W'(RA_DB_OUT))   pci_rdata_d = ob_db;
      if (pci_word == WORD_W'(RA_DB_IN))    pci_rdata_d = ib_db;
      if (pci_word == WORD_W'(RA_IN_CAUSE)) pci_rdata_d = DATA_W'(in_cause);
      if (pci_word == WORD_W'(RA_IN_MASK))  pci_rdata_d = DATA_W'(in_mask);
      if (pci_word == WORD_W'(RA_OB_CAUSE)) pci_rdata_d = DATA_W'(ob_cause);
      if (pci_word == WORD_W'(RA_OB_MASK))  pci_rdata_d = DATA_W'(ob_mask);
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      cpu_rdata <= '0;
      pci_rdata <= '0;
    end else begin
      if (cpu_rd) cpu_rdata <= cpu_rdata_d;
      if (pci_rd) pci_rdata <= pci_rdata_d;
    end
  end
endmodule

// File: rtl/mdu_checker.sv
`timescale 1ns/1ps
module mdu_checker
  import mdu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic              cpu_wr,
  input logic [ADDR_W-1:0] pci_addr,
  input logic              pci_wr,
  input logic              pci_rd,
  input logic [CAUSE_W-1:0] in_cause,
  input logic [CAUSE_W-1:0] in_mask,
  input logic [CAUSE_W-1:0] ob_cause,
  input logic [CAUSE_W-1:0] ob_mask,
  input logic [DATA_W-1:0] ob_db,
  input logic [DATA_W-1:0] ib_db,
  input logic              irq_cpu,
  input logic              irq_pci
);
  localparam logic [ADDR_W-1:0] A_OWN0  = ADDR_W'(4 * RA_OWN_MSG0);
  localparam logic [ADDR_W-1:0] A_PEER0 = ADDR_W'(4 * RA_PEER_MSG0);
  localparam logic [ADDR_W-1:0] A_DBO   = ADDR_W'(4 * RA_DB_OUT);
  localparam logic [ADDR_W-1:0] A_DBI   = ADDR_W'(4 * RA_DB_IN);

  assert_irq_cpu_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_cpu == $past(|(in_cause & ~in_mask & IRQ_SRC)));

  assert_irq_pci_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pci == $past(|(ob_cause & ~ob_mask & IRQ_SRC)));

  assert_obmsg_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ob_cause[CB_MSG0]) |-> $past(pci_rd && pci_addr == A_PEER0));

  assert_obdb_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(ob_db) & ~ob_db)) |-> $past(pci_wr && pci_addr == A_DBO));

  assert_ibdb_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(ib_db) & ~ib_db)) |-> $past(cpu_wr && cpu_addr == A_DBI));

  assert_obmsg_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr == A_OWN0) |=> ob_cause[CB_MSG0]);
endmodule

bind msg_doorbell_unit mdu_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
  .pci_addr(pci_addr), .pci_wr(pci_wr), .pci_rd(pci_rd),
  .in_cause(in_cause), .in_mask(in_mask), .ob_cause(ob_cause), .ob_mask(ob_mask),
  .ob_db(ob_db), .ib_db(ib_db), .irq_cpu(irq_cpu), .irq_pci(irq_pci)
);

// File: tb/msg_doorbell_unit_tb_top.sv
`timescale 1ns/1ps
module msg_doorbell_unit_tb_top;
  localparam int DW = 32;
  localparam int AW = 6;

  logic clk = 1'b0;
  logic rst_n;
  logic [AW-1:0] cpu_addr, pci_addr;
  logic cpu_wr, cpu_rd, pci_wr, pci_rd, queue_post_evt;
  logic [DW-1:0] cpu_wdata, pci_wdata, cpu_rdata, pci_rdata;
  logic irq_cpu, irq_pci;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  msg_doorbell_unit #(.DATA_W(DW), .ADDR_W(AW), .N_MSG(2)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .cpu_addr(cpu_addr), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .pci_addr(pci_addr), .pci_wr(pci_wr), .pci_rd(pci_rd),
    .pci_wdata(pci_wdata), .pci_rdata(pci_rdata),
    .queue_post_evt(queue_post_evt), .irq_cpu(irq_cpu), .irq_pci(irq_pci)
  );

  task automatic chk(input string req, input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic idle_bus();
    cpu_wr = 0; cpu_rd = 0; pci_wr = 0; pci_rd = 0; queue_post_evt = 0;
  endtask

  task automatic cycle();
    @(negedge clk);
  endtask

  task automatic cpu_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk); cpu_addr = a; cpu_wdata = d; cpu_wr = 1;
    @(negedge clk); cpu_wr = 0;
  endtask

  task automatic pci_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk); pci_addr = a; pci_wdata = d; pci_wr = 1;
    @(negedge clk); pci_wr = 0;
  endtask

  task automatic cpu_read(input logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge clk); cpu_addr = a; cpu_rd = 1;
    @(negedge clk); cpu_rd = 0; d = cpu_rdata;
  endtask

  task automatic pci_read(input logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge clk); pci_addr = a; pci_rd = 1;
    @(negedge clk); pci_rd = 0; d = pci_rdata;
  endtask

  // ---- scenarios ----
  task automatic t_reset();
    logic [DW-1:0] v;
    cpu_read(6'h00, v); chk("R1", "out msg0", v, 0);
    cpu_read(6'h08, v); chk("R1", "in msg0", v, 0);
    cpu_read(6'h10, v); chk("R1", "out doorbell", v, 0);
    cpu_read(6'h18, v); chk("R1", "in cause", v, 0);
    cpu_read(6'h1C, v); chk("R1", "in mask", v, 32'h1F);
    pci_read(6'h24, v); chk("R1", "out mask", v, 32'h1F);
    chk("R1", "irq_cpu", {31'd0, irq_cpu}, 0);
    chk("R1", "irq_pci", {31'd0, irq_pci}, 0);
  endtask

  task automatic t_out_msg();
    logic [DW-1:0] v;
    cpu_write(6'h00, 32'hA5A5_0001);
    cpu_write(6'h04, 32'h5A5A_0002);
    cpu_read(6'h20, v);  chk("R2", "out cause after posts", v, 32'h3);
    cpu_write(6'h20, 32'hFFFF_FFFF);
    cpu_read(6'h20, v);  chk("R3", "out cause after cpu write", v, 32'h3);
    pci_read(6'h08, v);  chk("R2", "pci reads out msg0", v, 32'hA5A5_0001);
    cpu_read(6'h20, v);  chk("R3", "out cause after msg0 read", v, 32'h2);
    pci_read(6'h0C, v);  chk("R2", "pci reads out msg1", v, 32'h5A5A_0002);
    cpu_read(6'h20, v);  chk("R3", "out cause after msg1 read", v, 32'h0);
  endtask

  task automatic t_in_msg();
    logic [DW-1:0] v;
    pci_write(6'h00, 32'h1234_5678);
    pci_write(6'h04, 32'h9ABC_DEF0);
    cpu_read(6'h08, v);  chk("R4", "cpu reads in msg0", v, 32'h1234_5678);
    cpu_read(6'h0C, v);  chk("R4", "cpu reads in msg1", v, 32'h9ABC_DEF0);
    cpu_read(6'h18, v);  chk("R4", "in cause set", v, 32'h3);
    pci_write(6'h18, 32'hFFFF_FFFF);
    cpu_read(6'h18, v);  chk("R4", "pci write to in cause ignored", v, 32'h3);
    cpu_write(6'h18, 32'h1);
    cpu_read(6'h18, v);  chk("R4", "clear bit0", v, 32'h2);
    cpu_write(6'h18, 32'h2);
    cpu_read(6'h18, v);  chk("R4", "clear bit1", v, 32'h0);
  endtask

  task automatic t_out_db();
    logic [DW-1:0] v;
    cpu_write(6'h10, 32'h0000_0081);
    cpu_write(6'h10, 32'h0);
    cpu_read(6'h10, v);  chk("R5", "zero write no effect", v, 32'h81);
    cpu_write(6'h10, 32'h0000_0100);
    pci_read(6'h10, v);  chk("R5", "set accumulates", v, 32'h181);
    cpu_read(6'h20, v);  chk("R5", "out cause db bit", v, 32'h4);
    pci_write(6'h10, 32'h81);
    cpu_read(6'h10, v);  chk("R5", "pci partial clear", v, 32'h100);
    cpu_read(6'h20, v);  chk("R5", "cause held while bits remain", v, 32'h4);
    pci_write(6'h10, 32'h100);
    cpu_read(6'h20, v);  chk("R5", "cause clear when empty", v, 32'h0);
  endtask

  task automatic t_in_db();
    logic [DW-1:0] v;
    pci_write(6'h14, 32'h3);
    pci_write(6'h14, 32'h0);
    cpu_read(6'h14, v);  chk("R6", "in doorbell set", v, 32'h3);
    cpu_read(6'h18, v);  chk("R6", "in cause db bit", v, 32'h4);
    pci_write(6'h14, 32'h0);
    cpu_write(6'h14, 32'h1);
    cpu_read(6'h14, v);  chk("R6", "cpu clear bit0", v, 32'h2);
    cpu_write(6'h14, 32'h2);
    cpu_read(6'h18, v);  chk("R6", "in cause clear", v, 32'h0);
  endtask

  task automatic t_queue();
    logic [DW-1:0] v;
    @(negedge clk); queue_post_evt = 1;
    @(negedge clk); queue_post_evt = 0;
    repeat (3) cycle();
    cpu_read(6'h18, v);  chk("R7", "queue cause sticky, bit3 zero", v, 32'h10);
    cpu_write(6'h18, 32'h0F);
    cpu_read(6'h18, v);  chk("R7", "other bits do not clear it", v, 32'h10);
    cpu_write(6'h18, 32'h10);
    cpu_read(6'h18, v);  chk("R7", "queue cause cleared", v, 32'h0);
  endtask

  task automatic t_irq();
    logic [DW-1:0] v;
    cpu_write(6'h1C, 32'h0);                    // unmask all inbound
    pci_write(6'h00, 32'hCAFE_0000);
    chk("R9", "irq_cpu one cycle late", {31'd0, irq_cpu}, 0);
    cycle();
    chk("R9", "irq_cpu raised", {31'd0, irq_cpu}, 1);
    pci_write(6'h14, 32'h1);
    cpu_write(6'h18, 32'h1);
    cycle();
    chk("R9", "irq_cpu held by doorbell", {31'd0, irq_cpu}, 1);
    cpu_write(6'h14, 32'h1);
    chk("R9", "irq_cpu still high before register", {31'd0, irq_cpu}, 1);
    cycle();
    chk("R9", "irq_cpu dropped", {31'd0, irq_cpu}, 0);
    // masking keeps the cause but hides it
    cpu_write(6'h1C, 32'h1);
    pci_write(6'h00, 32'hCAFE_0001);
    cycle();
    chk("R8", "masked cause no irq", {31'd0, irq_cpu}, 0);
    cpu_read(6'h18, v); chk("R8", "masked cause recorded", v, 32'h1);
    cpu_write(6'h1C, 32'h0);
    cycle();
    chk("R8", "unmask raises irq", {31'd0, irq_cpu}, 1);
    cpu_write(6'h18, 32'h1);
    cycle();
    chk("R9", "irq_cpu low after clear", {31'd0, irq_cpu}, 0);
    // outbound: doorbell unmasked only
    cpu_write(6'h24, 32'h1B);
    pci_read(6'h1C, v); chk("R8", "pci sees in mask", v, 32'h0);
    cpu_write(6'h00, 32'h0000_BEEF);
    cycle();
    chk("R8", "out msg masked", {31'd0, irq_pci}, 0);
    cpu_write(6'h10, 32'h20);
    cycle();
    chk("R9", "irq_pci on doorbell", {31'd0, irq_pci}, 1);
    pci_write(6'h10, 32'h20);
    cycle();
    chk("R9", "irq_pci cleared", {31'd0, irq_pci}, 0);
    pci_read(6'h08, v); chk("R2", "out msg0 data", v, 32'h0000_BEEF);
  endtask

  task automatic t_collide();
    logic [DW-1:0] v;
    cpu_write(6'h04, 32'h1111_1111);
    @(negedge clk);
    cpu_addr = 6'h04; cpu_wdata = 32'h2222_2222; cpu_wr = 1;
    pci_addr = 6'h0C; pci_rd = 1;
    @(negedge clk); cpu_wr = 0; pci_rd = 0;
    chk("R10", "read returned old msg1", pci_rdata, 32'h1111_1111);
    cpu_read(6'h20, v); chk("R10", "msg1 cause survives read", v, 32'h2);
    pci_read(6'h0C, v); chk("R10", "new msg1 data", v, 32'h2222_2222);
    cpu_read(6'h20, v); chk("R10", "msg1 cause now clear", v, 32'h0);
    pci_write(6'h14, 32'h80);
    @(negedge clk);
    cpu_addr = 6'h14; cpu_wdata = 32'h80; cpu_wr = 1;
    pci_addr = 6'h14; pci_wdata = 32'h80; pci_wr = 1;
    @(negedge clk); cpu_wr = 0; pci_wr = 0;
    cpu_read(6'h14, v); chk("R10", "doorbell set beats clear", v, 32'h80);
    cpu_write(6'h14, 32'h80);
    cpu_read(6'h14, v); chk("R10", "doorbell then cleared", v, 32'h0);
  endtask

  task automatic t_readport();
    logic [DW-1:0] v;
    pci_write(6'h00, 32'hDEAD_0001);
    cpu_read(6'h08, v); chk("R11", "read data", v, 32'hDEAD_0001);
    pci_write(6'h00, 32'hDEAD_0002);
    cycle();
    chk("R11", "rdata holds without strobe", cpu_rdata, 32'hDEAD_0001);
    cpu_read(6'h2C, v); chk("R11", "unmapped reads 0", v, 32'h0);
    cpu_read(6'h09, v); chk("R11", "misaligned reads 0", v, 32'h0);
    cpu_write(6'h11, 32'hFF);
    cpu_read(6'h10, v); chk("R11", "misaligned write ignored", v, 32'h0);
    cpu_write(6'h18, 32'h1);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 0; cpu_addr = '0; pci_addr = '0; cpu_wdata = '0; pci_wdata = '0;
    idle_bus();
    repeat (4) cycle();
    rst_n = 1;
    repeat (4) cycle();
    t_reset();
    t_out_msg();
    t_in_msg();
    t_out_db();
    t_in_db();
    t_queue();
    t_irq();
    t_collide();
    t_readport();
    repeat (2) cycle();
    finish_run();
  end
endmodule